// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block holds the single reservation of one hart and settles load-reserved / store-conditional pairs. A load-reserved request aligns its address to its access size and stores it as the live reservation. A store-conditional request is resolved in the same cycle it is presented. The block compares the aligned store address against the live reservation. It then grants or withholds the memory write, returns a destination value, and raises the acquire/release ordering request. That request is raised whether the store-conditional succeeds or fails.

The reservation is dropped in four cases: on reset, whenever the privilege mode differs from the previous cycle, after every store-conditional, and when an external invalidate hits the reserved doubleword. This keeps a reservation from leaking between contexts and keeps a later store-conditional from succeeding on a stale pair. The state machine has two states. RESV_NONE moves to RESV_HELD on a load-reserved. RESV_HELD stays in RESV_HELD on a load-reserved, which replaces the address. It falls back to RESV_NONE on a store-conditional, a mode change or an invalidate hit that comes without a load-reserved. In every other case each state holds.

Top module: `lrsc_resv_monitor`

## Requirements
- R1: After reset no reservation is held, so a store-conditional before any load-reserved fails.
- R2: A load-reserved stores its address with the low 2 bits cleared when `lr_dword_i`=0 (word) or the low 3 bits cleared when `lr_dword_i`=1 (doubleword). A store-conditional succeeds when a reservation is live and its own address, aligned the same way by `sc_dword_i`, equals the stored one.
- R3: Every store-conditional drops the reservation at the next edge, whether it succeeded or failed.
- R4: A store-conditional fails on an address mismatch or with no reservation. `sc_grant_o` is high only in the cycle of a successful store-conditional.
- R5: `sc_rd_we_o` is high in every store-conditional cycle and low otherwise. `sc_rd_val_o` is 0 on success and 1 on failure.
- R6: `fence_o` equals {acquire, release} (bit 1 acquire, bit 0 release) in every store-conditional cycle on both outcomes, and is 0 in all other cycles.
- R7: When `priv_i` differs from its value in the previous cycle (2'b11 just after reset), the reservation is dead at once. A store-conditional in that cycle fails, and the reservation is gone afterwards.
- R8: A new load-reserved replaces an older reservation.
- R9: A load-reserved in the same cycle as a mode change, an invalidate hit or a store-conditional leaves its new reservation in place. A store-conditional in that cycle is resolved against the old state.
- R10: `inval_i` whose address equals the reserved address with the low 3 bits ignored kills the reservation at once, failing a same-cycle store-conditional. An invalidate to any other doubleword has no effect.
- R11: Resolution is combinational in the request cycle. A load-reserved is visible to a store-conditional one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_i | input | 2 | Current privilege mode |
| lr_req_i | input | 1 | Load-reserved request |
| lr_addr_i | input | ADDR_W | Load-reserved byte address |
| lr_dword_i | input | 1 | Load-reserved size: 0 word, 1 doubleword |
| sc_req_i | input | 1 | Store-conditional request |
| sc_addr_i | input | ADDR_W | Store-conditional byte address |
| sc_dword_i | input | 1 | Store-conditional size: 0 word, 1 doubleword |
| sc_aq_i | input | 1 | Acquire bit of the store-conditional |
| sc_rl_i | input | 1 | Release bit of the store-conditional |
| inval_i | input | 1 | External invalidate strobe |
| inval_addr_i | input | ADDR_W | Address of the external invalidate |
| sc_grant_o | output | 1 | Memory write grant |
| sc_rd_we_o | output | 1 | Destination write enable |
| sc_rd_val_o | output | XLEN | Destination value, 0 success, 1 failure |
| fence_o | output | 2 | Ordering request {acquire, release} |

## Verification
The bench targets the pair boundaries. A store-conditional straight after reset must fail, and a second store-conditional after a successful one must also fail. A design that kept the reservation would grant both. Mode changes and invalidates that land in the same cycle as a store-conditional must fail it at once. A design that registered the kill first would let that store through. A load-reserved paired with a mode change must survive, and a clear-wins design would lose it. Mixed word and doubleword alignments around the same doubleword expose a wrong mask, and the random phase checks the ordering request on failed stores, which a success-only fence would drop.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
    typedef enum logic {
        RESV_NONE = 1'b0,
        RESV_HELD = 1'b1
    } resv_state_e;

    localparam logic [1:0] PRIV_RESET = 2'b11;
endpackage

// File: rtl/lrsc_addr_align.sv
module lrsc_addr_align #(
    parameter int ADDR_W    = 32,
    parameter int WORD_LG2  = 2,
    parameter int DWORD_LG2 = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              dword_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] keep;

    for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
        if (b >= DWORD_LG2) begin : g_high
            assign keep[b] = 1'b1;
        end else if (b >= WORD_LG2) begin : g_mid
            assign keep[b] = ~dword_i;
        end else begin : g_low
            assign keep[b] = 1'b0;
        end
    end

    assign addr_o = addr_i & keep;
endmodule

// File: rtl/lrsc_mode_watch.sv
module lrsc_mode_watch
    import lrsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] priv_i,
    output logic       mode_chg_o
);
    logic [1:0] priv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q <= PRIV_RESET;
        end else begin
            priv_q <= priv_i;
        end
    end

    assign mode_chg_o = (priv_i != priv_q);
endmodule

// File: rtl/lrsc_resv_fsm.sv
module lrsc_resv_fsm
    import lrsc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_req_i,
    input  logic [ADDR_W-1:0] lr_addr_al_i,
    input  logic              sc_req_i,
    input  logic              mode_chg_i,
    input  logic              inval_i,
    input  logic [ADDR_W-1:0] inval_addr_i,
    output logic              live_o,
    output logic [ADDR_W-1:0] resv_addr_o
);
    localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W)'((1 << GRAN_LG2) - 1));

    resv_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              inval_hit;
    logic              kill;

    assign inval_hit = inval_i && (((inval_addr_i ^ addr_q) & GRAN_MASK) == '0);
    assign kill      = sc_req_i || mode_chg_i || inval_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESV_NONE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (lr_req_i) begin
                addr_q <= lr_addr_al_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RESV_NONE: begin
                if (lr_req_i) begin
                    state_d = RESV_HELD;
                end
            end
            RESV_HELD: begin
                if (lr_req_i) begin
                    state_d = RESV_HELD;
                end else if (kill) begin
                    state_d = RESV_NONE;
                end
            end
            default: state_d = RESV_NONE;
        endcase
    end

    always_comb begin
        live_o      = (state_q == RESV_HELD) && !mode_chg_i && !inval_hit;
        resv_addr_o = addr_q;
    end
endmodule

// File: rtl/lrsc_sc_resolve.sv
module lrsc_sc_resolve #(
    parameter int ADDR_W = 32,
    parameter int XLEN   = 64
) (
    input  logic              sc_req_i,
    input  logic              sc_aq_i,
    input  logic              sc_rl_i,
    input  logic              live_i,
    input  logic [ADDR_W-1:0] resv_addr_i,
    input  logic [ADDR_W-1:0] sc_addr_al_i,
    output logic              grant_o,
    output logic              rd_we_o,
    output logic [XLEN-1:0]   rd_val_o,
    output logic [1:0]        fence_o
);
    logic pass;

    always_comb begin
        pass     = live_i && (sc_addr_al_i == resv_addr_i);
        grant_o  = sc_req_i && pass;
        rd_we_o  = sc_req_i;
        rd_val_o = '0;
        fence_o  = 2'b00;
        if (sc_req_i) begin
            rd_val_o[0] = ~pass;
            fence_o     = {sc_aq_i, sc_rl_i};
        end
    end
endmodule

// File: rtl/lrsc_resv_monitor.sv
module lrsc_resv_monitor #(
    parameter int ADDR_W = 32,
    parameter int XLEN   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        priv_i,
    input  logic              lr_req_i,
    input  logic [ADDR_W-1:0] lr_addr_i,
    input  logic              lr_dword_i,
    input  logic              sc_req_i,
    input  logic [ADDR_W-1:0] sc_addr_i,
    input  logic              sc_dword_i,
    input  logic              sc_aq_i,
    input  logic              sc_rl_i,
    input  logic              inval_i,
    input  logic [ADDR_W-1:0] inval_addr_i,
    output logic              sc_grant_o,
    output logic              sc_rd_we_o,
    output logic [XLEN-1:0]   sc_rd_val_o,
    output logic [1:0]        fence_o
);
    localparam int WORD_LG2  = 2;
    localparam int DWORD_LG2 = 3;

    logic [ADDR_W-1:0] lr_al, sc_al, resv_addr;
    logic              mode_chg, live;

    lrsc_addr_align #(.ADDR_W(ADDR_W), .WORD_LG2(WORD_LG2), .DWORD_LG2(DWORD_LG2)) u_lr_align (
        .addr_i(lr_addr_i), .dword_i(lr_dword_i), .addr_o(lr_al)
    );

    lrsc_addr_align #(.ADDR_W(ADDR_W), .WORD_LG2(WORD_LG2), .DWORD_LG2(DWORD_LG2)) u_sc_align (
        .addr_i(sc_addr_i), .dword_i(sc_dword_i), .addr_o(sc_al)
    );

    lrsc_mode_watch u_mode (
        .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .mode_chg_o(mode_chg)
    );

    lrsc_resv_fsm #(.ADDR_W(ADDR_W), .GRAN_LG2(DWORD_LG2)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .lr_req_i(lr_req_i), .lr_addr_al_i(lr_al),
        .sc_req_i(sc_req_i), .mode_chg_i(mode_chg),
        .inval_i(inval_i), .inval_addr_i(inval_addr_i),
        .live_o(live), .resv_addr_o(resv_addr)
    );

    lrsc_sc_resolve #(.ADDR_W(ADDR_W), .XLEN(XLEN)) u_res (
        .sc_req_i(sc_req_i), .sc_aq_i(sc_aq_i), .sc_rl_i(sc_rl_i),
        .live_i(live), .resv_addr_i(resv_addr), .sc_addr_al_i(sc_al),
        .grant_o(sc_grant_o), .rd_we_o(sc_rd_we_o),
        .rd_val_o(sc_rd_val_o), .fence_o(fence_o)
    );
endmodule

// File: rtl/lrsc_resv_monitor_chk.sv
module lrsc_resv_monitor_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      priv_i,
    input logic            lr_req_i,
    input logic            sc_req_i,
    input logic            sc_aq_i,
    input logic            sc_rl_i,
    input logic            sc_grant_o,
    input logic            sc_rd_we_o,
    input logic [XLEN-1:0] sc_rd_val_o,
    input logic [1:0]      fence_o
);
    a_r4_grant_only_on_sc: assert property (@(posedge clk) disable iff (!rst_n)
        sc_grant_o |-> sc_req_i);

    a_r5_result_matches_grant: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req_i |-> (sc_rd_we_o && (sc_rd_val_o == (sc_grant_o ? '0 : XLEN'(1)))));

    a_r6_fence_both_outcomes: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req_i |-> (fence_o == {sc_aq_i, sc_rl_i}));

    a_r6_fence_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_req_i |-> (fence_o == 2'b00 && !sc_rd_we_o));

    a_r3_sc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req_i && !lr_req_i) |=> !sc_grant_o);

    a_r7_mode_change_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req_i && (priv_i != $past(priv_i))) |-> !sc_grant_o);
endmodule

bind lrsc_resv_monitor lrsc_resv_monitor_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .lr_req_i(lr_req_i),
    .sc_req_i(sc_req_i), .sc_aq_i(sc_aq_i), .sc_rl_i(sc_rl_i),
    .sc_grant_o(sc_grant_o), .sc_rd_we_o(sc_rd_we_o),
    .sc_rd_val_o(sc_rd_val_o), .fence_o(fence_o)
);

// File: tb/lrsc_resv_monitor_tb.sv
`timescale 1ns/1ps
module lrsc_resv_monitor_tb;
    localparam int ADDR_W = 32;
    localparam int XLEN   = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        priv_i = 2'b11;
    logic              lr_req_i = 1'b0, lr_dword_i = 1'b0;
    logic [ADDR_W-1:0] lr_addr_i = '0, sc_addr_i = '0, inval_addr_i = '0;
    logic              sc_req_i = 1'b0, sc_dword_i = 1'b0, sc_aq_i = 1'b0, sc_rl_i = 1'b0;
    logic              inval_i = 1'b0;
    logic              sc_grant_o, sc_rd_we_o;
    logic [XLEN-1:0]   sc_rd_val_o;
    logic [1:0]        fence_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    bit              m_valid = 1'b0;
    logic [31:0]     m_addr  = '0;
    logic [1:0]      m_prev  = 2'b11;

    always #2 clk = ~clk;

    lrsc_resv_monitor #(.ADDR_W(ADDR_W), .XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .priv_i(priv_i),
        .lr_req_i(lr_req_i), .lr_addr_i(lr_addr_i), .lr_dword_i(lr_dword_i),
        .sc_req_i(sc_req_i), .sc_addr_i(sc_addr_i), .sc_dword_i(sc_dword_i),
        .sc_aq_i(sc_aq_i), .sc_rl_i(sc_rl_i),
        .inval_i(inval_i), .inval_addr_i(inval_addr_i),
        .sc_grant_o(sc_grant_o), .sc_rd_we_o(sc_rd_we_o),
        .sc_rd_val_o(sc_rd_val_o), .fence_o(fence_o)
    );

    function automatic logic [31:0] align(input logic [31:0] a, input bit dw);
        return dw ? (a & ~32'h7) : (a & ~32'h3);
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check combinational outputs, update model
    task automatic step(input string req, input bit lr, input logic [31:0] la, input bit ldw,
                        input bit sc, input logic [31:0] sa, input bit sdw,
                        input bit aq, input bit rl, input logic [1:0] pv,
                        input bit inv, input logic [31:0] ia,
                        input int expect_ok);
        bit chg, hit, live, ok;
        @(negedge clk);
        lr_req_i = lr; lr_addr_i = la; lr_dword_i = ldw;
        sc_req_i = sc; sc_addr_i = sa; sc_dword_i = sdw; sc_aq_i = aq; sc_rl_i = rl;
        priv_i = pv; inval_i = inv; inval_addr_i = ia;
        #1;
        chg  = (pv != m_prev);
        hit  = inv && ((ia & ~32'h7) == (m_addr & ~32'h7));
        live = m_valid && !chg && !hit;
        ok   = live && (align(sa, sdw) == m_addr);
        if (expect_ok >= 0) check({req, " directed"}, 128'(ok), 128'(expect_ok));
        if (sc) begin
            check({req, "/R4 grant"}, 128'(sc_grant_o), 128'(ok));
            check({req, "/R5 result"}, 128'({sc_rd_we_o, sc_rd_val_o}), 128'({1'b1, 64'(!ok)}));
            check({req, "/R6 fence"}, 128'(fence_o), 128'({aq, rl}));
        end else begin
            check({req, "/R6 idle"}, 128'({sc_grant_o, sc_rd_we_o, fence_o}), 128'(0));
        end
        if (lr) begin
            m_valid = 1'b1;
            m_addr  = align(la, ldw);
        end else if (m_valid && (sc || chg || hit)) begin
            m_valid = 1'b0;
        end
        m_prev = pv;
    endtask

    function automatic logic [31:0] pool_addr();
        return 32'h1000 + ($urandom_range(0, 3) << 3) + $urandom_range(0, 7);
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset outputs", 128'({sc_grant_o, sc_rd_we_o, fence_o}), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // R1: store-conditional before any load-reserved
        step("R1", 0, 0, 0, 1, 32'h1000, 0, 1, 0, 2'b11, 0, 0, 0);
        // R11/R2: reserve, succeed one cycle later, word alignment
        step("R11", 1, 32'h1003, 0, 0, 0, 0, 0, 0, 2'b11, 0, 0, -1);
        step("R2 word", 0, 0, 0, 1, 32'h1001, 0, 1, 1, 2'b11, 0, 0, 1);
        // R3: second SC fails
        step("R3", 0, 0, 0, 1, 32'h1001, 0, 0, 1, 2'b11, 0, 0, 0);
        // R2 doubleword mask vs word at +4
        step("R2", 1, 32'h1106, 1, 0, 0, 0, 0, 0, 2'b11, 0, 0, -1);
        step("R2 dword mismatch", 0, 0, 0, 1, 32'h1104, 0, 0, 0, 2'b11, 0, 0, 0);
        step("R2", 1, 32'h1106, 1, 0, 0, 0, 0, 0, 2'b11, 0, 0, -1);
        step("R2 dword", 0, 0, 0, 1, 32'h1101, 1, 0, 0, 2'b11, 0, 0, 1);
        // R8: replacement
        step("R8", 1, 32'h2000, 0, 0, 0, 0, 0, 0, 2'b11, 0, 0, -1);
        step("R8", 1, 32'h3000, 0, 0, 0, 0, 0, 0, 2'b11, 0, 0, -1);
        step("R8 old", 0, 0, 0, 1, 32'h2000, 0, 1, 0, 2'b11, 0, 0, 0);
        step("R8", 1, 32'h3000, 0, 0, 0, 0, 0, 0, 2'b11, 0, 0, -1);
        step("R8 new", 0, 0, 0, 1, 32'h3000, 0, 0, 0, 2'b11, 0, 0, 1);
        // R7: mode change same cycle as SC fails (fence still raised)
        step("R7", 1, 32'h4000, 0, 0, 0, 0, 0, 0, 2'b11, 0, 0, -1);
        step("R7 same cycle", 0, 0, 0, 1, 32'h4000, 0, 1, 1, 2'b01, 0, 0, 0);
        step("R7", 1, 32'h4000, 0, 0, 0, 0, 0, 0, 2'b01, 0, 0, -1);
        step("R7 idle change", 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, -1);
        step("R7 after", 0, 0, 0, 1, 32'h4000, 0, 0, 0, 2'b00, 0, 0, 0);
        // R9: LR with mode change survives; LR with SC survives
        step("R9 lr+chg", 1, 32'h5000, 0, 0, 0, 0, 0, 0, 2'b11, 0, 0, -1);
        step("R9 lr+chg", 0, 0, 0, 1, 32'h5000, 0, 0, 0, 2'b11, 0, 0, 1);
        step("R9 lr+sc", 1, 32'h5100, 0, 1, 32'h5100, 0, 0, 0, 2'b11, 0, 0, 0);
        step("R9 lr+sc", 0, 0, 0, 1, 32'h5100, 0, 0, 0, 2'b11, 0, 0, 1);
        // R10: invalidate miss has no effect, hit fails same-cycle SC
        step("R10", 1, 32'h6000, 0, 0, 0, 0, 0, 0, 2'b11, 0, 0, -1);
        step("R10 miss", 0, 0, 0, 0, 0, 0, 0, 0, 2'b11, 1, 32'h6008, -1);
        step("R10 miss", 0, 0, 0, 1, 32'h6000, 0, 0, 0, 2'b11, 0, 0, 1);
        step("R10", 1, 32'h6000, 0, 0, 0, 0, 0, 0, 2'b11, 0, 0, -1);
        step("R10 hit", 0, 0, 0, 1, 32'h6000, 0, 0, 1, 2'b11, 1, 32'h6005, 0);
        step("R10", 1, 32'h6000, 0, 0, 0, 0, 0, 0, 2'b11, 1, 32'h6004, -1);
        step("R10 lr+inv", 0, 0, 0, 1, 32'h6000, 0, 0, 0, 2'b11, 0, 0, 1);

        // random phase
        for (int i = 0; i < 2000; i++) begin
            int op;
            logic [1:0] pv;
            op = $urandom_range(0, 3);
            pv = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(0, 3)) : m_prev;
            step("R4/R5/R6 random", op == 0, pool_addr(), 1'($urandom_range(0, 1)),
                 op == 1, pool_addr(), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), pv,
                 $urandom_range(0, 7) == 0, pool_addr(), -1);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule